// File: doc/BRIEF.md
# PCI configuration cycle address generator

This block sits between a host port and a PCI configuration engine. It takes one configuration request at a time, made up of a bus number, a device/function byte, a register offset, an access size and a read or write flag with write data, and turns it into a formatted configuration address, a type 0 or type 1 flag, a host sparse-space address that carries the access size, and write data moved onto the correct byte lanes. A request on bus zero becomes a type 0 cycle whose device is picked by a single one-hot select bit. A request on any other bus becomes a type 1 cycle that is forwarded to bridges downstream.

While a type 1 cycle is on the bus, the block overrides the top bits of a host window control word. The incoming window value is passed through unchanged at all other times, so ordinary I/O accesses see their own setting. When the cycle finishes, read data is returned moved down to bit 0. A read that ends in a master abort returns all ones. A write that ends in a master abort only raises a sticky error flag. A type 0 request for a device number above the supported limit issues no cycle and is acknowledged with a device-not-found indication.

Top module: `cfgcyc_gen`

## Requirements
- R1: After reset, host_ack, cyc_valid and err_flag are low, and win_eff equals win_base.
- R2: When host_bus is 0 the cycle is type 0 (cyc_type1 low). cyc_addr has exactly one bit set in 31:11, at bit 11+d, where d is host_devfn[7:3]. The function host_devfn[2:0] is in bits 10:8, host_off[7:2] is in bits 7:2, and bits 1:0 are 00.
- R3: When host_bus is 0 and host_devfn[7:3] is greater than MAX_DEV (default 8), no cycle is issued. In the cycle after the request, host_ack and host_nodev are both high. host_nodev is low on every acknowledged request that did issue a cycle.
- R4: When host_bus is nonzero the cycle is type 1 (cyc_type1 high). cyc_addr has host_bus in bits 23:16, host_devfn in bits 15:8, host_off[7:2] in bits 7:2, bits 1:0 equal to 01, and bits 31:24 equal to zero.
- R5: cyc_sparse equals cyc_addr shifted left by 5, plus a size code. host_size 0 (byte) adds 0x00, host_size 1 (word) adds 0x08, and host_size 2 or 3 (dword) adds 0x18.
- R6: For a byte or word read, host_rdata is the returned dword shifted right by 8×host_off[1:0]. The upper bits are not masked. A dword read returns the dword unchanged.
- R7: For a byte or word write, cyc_wdata is host_wdata shifted left by 8×host_off[1:0]. A dword write passes host_wdata unchanged.
- R8: A read that completes with cyc_abort high returns 0xFFFFFFFF on host_rdata, whatever its size and offset.
- R9: While a type 1 cycle is outstanding, win_eff is win_base with bit 31 cleared and bit 30 set. At all other times win_eff equals win_base.
- R10: A request is a one-cycle pulse on host_req and is accepted only when the block is idle. Pulses that arrive while a cycle is outstanding or while the acknowledge is showing are ignored. cyc_valid stays high, with its address stable, until cyc_done. host_ack is a single-cycle pulse in the cycle after cyc_done.
- R11: A write that completes with cyc_abort high sets err_flag. err_flag stays set until err_clear is high at a clock edge. If the set and the clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Request pulse |
| host_bus | input | 8 | Bus number |
| host_devfn | input | 8 | Device (7:3) and function (2:0) |
| host_off | input | 8 | Register byte offset |
| host_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| host_wr | input | 1 | 1 write, 0 read |
| host_wdata | input | 32 | Write data, right-aligned |
| host_ack | output | 1 | Completion pulse |
| host_nodev | output | 1 | Device not found, valid with host_ack |
| host_rdata | output | 32 | Read data, valid with host_ack |
| err_flag | output | 1 | Sticky write-abort flag |
| err_clear | input | 1 | Clears err_flag |
| cyc_valid | output | 1 | Configuration cycle outstanding |
| cyc_type1 | output | 1 | Type 1 cycle |
| cyc_wr | output | 1 | Cycle is a write |
| cyc_addr | output | 32 | Configuration address |
| cyc_sparse | output | 37 | Host sparse address with size code |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_done | input | 1 | Target completed the cycle |
| cyc_abort | input | 1 | Completion was a master abort |
| cyc_rdata | input | 32 | Returned dword |
| win_base | input | 32 | Host window control value |
| win_eff | output | 32 | Effective window control value |

## Verification
The bench targets these boundary cases:
- Device 8 is the last one accepted on bus 0, and devices 9 and 31 must be refused. A limit that is off by one either issues a cycle to a nonexistent select line or refuses a legal device.
- Offsets with the low two bits set to 3 expose lane shifts that went the wrong way or that also shift dwords.
- An abort on a read must give all ones rather than shifted bus data. An abort on a write must leave host_rdata alone and set only the flag, including when a clear arrives on the same edge.
- Request pulses are injected during the outstanding cycle and during the acknowledge. A block that does not guard its idle state would then re-issue a cycle or corrupt the latched address.
- The window override is checked on every clock, which catches one that stays on after a type 1 cycle or appears on type 0 cycles.

// File: rtl/cfgcyc_gen.sv
module cfgcyc_gen #(
  parameter int MAX_DEV = 8,
  parameter int SPARSE_SHIFT = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      host_req,
  input  logic [7:0]                host_bus,
  input  logic [7:0]                host_devfn,
  input  logic [7:0]                host_off,
  input  logic [1:0]                host_size,
  input  logic                      host_wr,
  input  logic [31:0]               host_wdata,
  output logic                      host_ack,
  output logic                      host_nodev,
  output logic [31:0]               host_rdata,
  output logic                      err_flag,
  input  logic                      err_clear,
  output logic                      cyc_valid,
  output logic                      cyc_type1,
  output logic                      cyc_wr,
  output logic [31:0]               cyc_addr,
  output logic [31+SPARSE_SHIFT:0]  cyc_sparse,
  output logic [31:0]               cyc_wdata,
  input  logic                      cyc_done,
  input  logic                      cyc_abort,
  input  logic [31:0]               cyc_rdata,
  input  logic [31:0]               win_base,
  output logic [31:0]               win_eff
);
  localparam int SW = 32 + SPARSE_SHIFT;
  localparam int NSEL = 21;

  typedef enum logic [1:0] {S_IDLE, S_CYC, S_ACK} st_t;
  st_t st;

  logic [4:0]  dev;
  logic        is_t0, bad;
  logic [31:0] t0_sel, addr_nxt;
  logic [1:0]  lane, lane_q;
  logic [4:0]  code;

  assign dev   = host_devfn[7:3];
  assign is_t0 = (host_bus == 8'd0);
  assign bad   = is_t0 && (32'(dev) > 32'(MAX_DEV));
  assign lane  = host_size[1] ? 2'd0 : host_off[1:0];
  assign code  = (host_size == 2'd0) ? 5'h00 : (host_size == 2'd1) ? 5'h08 : 5'h18;

  always_comb begin
    t0_sel = '0;
    for (int i = 0; i < NSEL; i++)
      if (dev == 5'(i)) t0_sel[11+i] = 1'b1;
  end

  assign addr_nxt = is_t0 ? (t0_sel | {21'd0, host_devfn[2:0], host_off[7:2], 2'b00})
                          : {8'd0, host_bus, host_devfn, host_off[7:2], 2'b01};

  assign host_ack  = (st == S_ACK);
  assign cyc_valid = (st == S_CYC);
  assign win_eff   = (cyc_valid && cyc_type1) ? {2'b01, win_base[29:0]} : win_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cyc_type1  <= 1'b0;
      cyc_wr     <= 1'b0;
      cyc_addr   <= '0;
      cyc_sparse <= '0;
      cyc_wdata  <= '0;
      lane_q     <= '0;
      host_nodev <= 1'b0;
      host_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (host_req) begin
          host_nodev <= bad;
          if (bad) st <= S_ACK;
          else begin
            st         <= S_CYC;
            cyc_type1  <= !is_t0;
            cyc_wr     <= host_wr;
            cyc_addr   <= addr_nxt;
            cyc_sparse <= {addr_nxt, {SPARSE_SHIFT{1'b0}}} | SW'(code);
            cyc_wdata  <= host_wdata << {lane, 3'b000};
            lane_q     <= lane;
          end
        end
        S_CYC: if (cyc_done) begin
          st <= S_ACK;
          if (!cyc_wr)
            host_rdata <= cyc_abort ? 32'hFFFF_FFFF : (cyc_rdata >> {lane_q, 3'b000});
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_flag <= 1'b0;
    else if (cyc_valid && cyc_done && cyc_abort && cyc_wr) err_flag <= 1'b1;
    else if (err_clear) err_flag <= 1'b0;
  end
endmodule

// File: rtl/cfgcyc_chk.sv
module cfgcyc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_ack,
  input logic        host_nodev,
  input logic [31:0] host_rdata,
  input logic        cyc_valid,
  input logic        cyc_type1,
  input logic        cyc_wr,
  input logic [31:0] cyc_addr,
  input logic        cyc_done,
  input logic        cyc_abort,
  input logic [31:0] win_base,
  input logic [31:0] win_eff
);
  // R10
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  // R10
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_done) |=> (cyc_valid && $stable(cyc_addr)));
  // R3
  nodev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ack && host_nodev) |-> !cyc_valid);
  // R2
  t0_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && !cyc_type1) |-> ($countones(cyc_addr[31:11]) == 1 && cyc_addr[1:0] == 2'b00));
  // R4
  t1_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type1) |-> (cyc_addr[1:0] == 2'b01));
  // R9
  win_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type1) |-> (win_eff[31:30] == 2'b01 && win_eff[29:0] == win_base[29:0]));
  // R9
  win_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> (win_eff == win_base));
  // R8
  rd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_done && cyc_abort && !cyc_wr) |=> (host_ack && host_rdata == 32'hFFFF_FFFF));
endmodule

bind cfgcyc_gen cfgcyc_chk u_chk (.*);

// File: tb/cfgcyc_gen_test.sv
module cfgcyc_gen_test;
  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_wr = 0, err_clear = 0;
  logic [7:0] host_bus = 0, host_devfn = 0, host_off = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0, cyc_rdata = 0;
  logic cyc_done = 0, cyc_abort = 0;
  logic [31:0] win_base = 32'hC000_1234;
  logic host_ack, host_nodev, err_flag, cyc_valid, cyc_type1, cyc_wr;
  logic [31:0] host_rdata, cyc_addr, cyc_wdata, win_eff;
  logic [36:0] cyc_sparse;
  int vecs = 0, bad = 0;
  bit done_all = 0;

  always #2 clk = ~clk;

  cfgcyc_gen uut (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [7:0] bus, devfn, off, input logic [1:0] sz,
                      input logic wr, input logic [31:0] wd, input int lat,
                      input logic ab, input logic [31:0] rd, input logic clr_same, input logic poke);
    logic [31:0] ea, ewd, erd;
    logic [36:0] es;
    logic nodev;
    int sh;
    nodev = (bus == 0) && (devfn[7:3] > 8);
    sh = (sz >= 2) ? 0 : off[1:0] * 8;
    if (bus == 0) ea = (32'h800 << devfn[7:3]) + (32'(devfn[2:0]) << 8) + 32'(off & 8'hFC);
    else ea = (32'(bus) << 16) + (32'(devfn) << 8) + 32'(off & 8'hFC) + 1;
    es = {5'd0, ea} << 5;
    es = es + ((sz == 0) ? 37'h0 : (sz == 1) ? 37'h8 : 37'h18);
    ewd = wd << sh;
    erd = ab ? 32'hFFFF_FFFF : (rd >> sh);
    host_bus = bus; host_devfn = devfn; host_off = off; host_size = sz;
    host_wr = wr; host_wdata = wd; host_req = 1;
    @(negedge clk);
    host_req = 0;
    if (nodev) begin
      chk("R3 nodev ack", {host_ack, host_nodev, cyc_valid}, 3'b110);
      @(negedge clk);
      chk("R3 no cycle after", {host_ack, cyc_valid}, 2'b00);
      return;
    end
    for (int c = 0; c <= lat; c++) begin
      chk("R10 valid held", {cyc_valid, host_ack}, 2'b10);
      chk(bus == 0 ? "R2 type0 addr" : "R4 type1 addr", cyc_addr, ea);
      chk("R2/R4 type flag", cyc_type1, bus != 0);
      chk("R5 sparse", cyc_sparse, es);
      if (wr) chk("R7 wdata lanes", cyc_wdata, ewd);
      chk("R9 window during", win_eff, bus != 0 ? {2'b01, win_base[29:0]} : win_base);
      if (c == 0 && poke) begin
        host_bus = 8'h77; host_devfn = 8'h08; host_off = 8'h44; host_req = 1;
      end else host_req = 0;
      if (c == lat) begin
        cyc_done = 1; cyc_abort = ab; cyc_rdata = rd; err_clear = clr_same;
      end
      @(negedge clk);
    end
    cyc_done = 0; cyc_abort = 0; err_clear = 0; host_req = 0;
    chk("R10 ack pulse", {host_ack, host_nodev, cyc_valid}, 3'b100);
    if (!wr) chk(ab ? "R8 abort all ones" : "R6 read align", host_rdata, erd);
    if (wr && ab) chk("R11 err set", err_flag, 1);
    chk("R9 window restored", win_eff, win_base);
    if (poke) begin
      host_bus = 8'h03; host_devfn = 8'h00; host_req = 1;
    end
    @(negedge clk);
    host_req = 0;
    chk("R10 ignored reqs", {host_ack, cyc_valid}, 2'b00);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done_all) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1
    chk("R1 reset", {host_ack, cyc_valid, err_flag}, 3'b000);
    chk("R1 window", win_eff, win_base);
    rst_n = 1;
    @(negedge clk);
    xact(8'h00, {5'd3, 3'd2}, 8'h10, 2'd2, 0, 0, 2, 0, 32'h1234_5678, 0, 1);
    xact(8'h00, {5'd8, 3'd7}, 8'h3F, 2'd0, 0, 0, 0, 0, 32'hAABB_CCDD, 0, 0);
    xact(8'h00, {5'd0, 3'd1}, 8'h07, 2'd1, 0, 0, 1, 0, 32'h1111_2222, 0, 0);
    xact(8'h00, {5'd9, 3'd0}, 8'h00, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    xact(8'h00, {5'd31, 3'd7}, 8'h00, 2'd0, 1, 32'h55, 0, 0, 0, 0, 0);
    xact(8'h05, 8'h4B, 8'h22, 2'd1, 0, 0, 3, 0, 32'hDEAD_BEEF, 0, 1);
    xact(8'hFF, 8'hFF, 8'hFF, 2'd3, 0, 0, 0, 0, 32'hCAFE_F00D, 0, 0);
    xact(8'h02, 8'h10, 8'h41, 2'd0, 1, 32'h5A, 1, 0, 0, 0, 0);
    xact(8'h00, {5'd4, 3'd0}, 8'h0E, 2'd1, 1, 32'hBEEF, 0, 0, 0, 0, 0);
    chk("R11 no err on clean writes", err_flag, 0);
    xact(8'h03, 8'h08, 8'h13, 2'd0, 0, 0, 1, 1, 32'h1234_5678, 0, 0);
    xact(8'h00, {5'd2, 3'd0}, 8'h08, 2'd2, 1, 32'h0F0F_0F0F, 0, 1, 0, 0, 0);
    err_clear = 1; @(negedge clk); err_clear = 0;
    chk("R11 err cleared", err_flag, 0);
    xact(8'h01, 8'h00, 8'h00, 2'd2, 1, 32'h1, 2, 1, 0, 1, 0);
    chk("R11 set beats clear", err_flag, 1);
    @(negedge clk);
    chk("R11 err sticky", err_flag, 1);
    done_all = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule